// File: doc/BRIEF.md
# Bootstrap Switch Phase Sequencer

This block sequences the synchronous switch that charges a high-side bootstrap capacitor from the auxiliary supply in a half-bridge gate driver. The switch replaces a rectifier diode. A charging phase lasts exactly as long as the low-side power switch is commanded on. The sequencer closes the bootstrap switch once, at the start of each charging phase, and keeps it open for the rest of the time. When the switch is open it blocks current in both directions.

Two analog comparators feed the block as asynchronous digital flags. One reports reverse current flowing from the high-side rail back into the auxiliary supply. When it is seen, the switch opens and stays open until the phase ends. The other reports that the charging current is at its limit, which is set outside this block at a nominal 240 mA; the reverse detect sits near 15 mA. The current-limit circuit is enabled together with the switch so that a deeply discharged capacitor cannot overstress it. The limit circuit is disabled for the remainder of the phase as soon as the synchronized over-limit flag reads low, which saves quiescent current. A low auxiliary power-good input opens the switch and ends the phase.

Top module: `bst_phase_seq`

## Requirements
- R1: While `ls_cmd` is low at a rising clock edge, both `bst_gate_en` and `ilim_arm` are low after that edge. Both outputs are low during and after reset.
- R2: At the first rising edge where `ls_cmd` is high while the block is idle and `aux_good` is high, `bst_gate_en` goes high. The block is idle after reset and after any edge with `ls_cmd` low.
- R3: Once `bst_gate_en` has dropped within a phase, it stays low for every edge at which `ls_cmd` remains high. It does not rise again until `ls_cmd` has been seen low.
- R4: If the synchronized reverse-current flag is high at an edge while the switch is on and the phase continues, `bst_gate_en` goes low at that edge and `ilim_arm` goes low with it.
- R5: `ilim_arm` goes high on the same edge at which `bst_gate_en` turns on, and it is never high while `bst_gate_en` is low.
- R6: If the synchronized over-limit flag is low at an edge while the switch is on, `ilim_arm` goes low at that edge. It stays low for the rest of the phase even if the flag returns high.
- R7: `rev_flag` and `olim_flag` pass through a two-flop synchronizer. A flag value present at edge k is acted on at edge k+2, and it has no effect on the outputs at edges k and k+1.
- R8: While `aux_good` is low at an edge, both outputs are low after that edge. If `ls_cmd` is still high, the switch stays off for the rest of that phase even after `aux_good` returns high.
- R9: A phase whose start edge sees `aux_good` low never turns the switch on, even if `aux_good` rises while `ls_cmd` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| ls_cmd | input | 1 | Low-side on command, synchronous to `clk`; high marks a charging phase |
| rev_flag | input | 1 | Asynchronous reverse-current comparator flag |
| olim_flag | input | 1 | Asynchronous over-limit comparator flag |
| aux_good | input | 1 | Auxiliary supply power-good, synchronous to `clk` |
| bst_gate_en | output | 1 | Bootstrap switch gate enable |
| ilim_arm | output | 1 | Current-limit circuit enable |

## Verification
The hardest case to reach from the ports is a flag change that lands during the two-cycle synchronizer delay while the switch is still on. A reverse or over-limit flag raised just before turn-on, or a one-cycle reverse pulse, must act exactly two edges later. It must also never re-arm anything that has already been disarmed. Directed sequences place single-cycle pulses and flag drops at those exact offsets within a phase. Long random phases with sticky over-limit flags, sparse reverse pulses and occasional power-good drops then cover the combinations that remain.

// File: rtl/bst_seq_pkg.sv
package bst_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ON    = 2'd1,
    PH_SPENT = 2'd2
  } phase_t;

  localparam int unsigned FLAG_REV  = 0;
  localparam int unsigned FLAG_OLIM = 1;
  localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import bst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ls_on,
  input  logic pwr_good,
  input  logic rev_s,
  input  logic olim_s,
  output logic sw_en,
  output logic ilim_en
);
  phase_t state;
  logic   ilim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      ilim_q <= 1'b0;
    end else if (!ls_on) begin
      state  <= PH_IDLE;
      ilim_q <= 1'b0;
    end else if (!pwr_good) begin
      state  <= PH_SPENT;
      ilim_q <= 1'b0;
    end else begin
      unique case (state)
        PH_IDLE: begin
          state  <= PH_ON;
          ilim_q <= 1'b1;
        end
        PH_ON: begin
          if (rev_s) begin
            state  <= PH_SPENT;
            ilim_q <= 1'b0;
          end else if (!olim_s) begin
            ilim_q <= 1'b0;
          end
        end
        PH_SPENT: begin
          state <= PH_SPENT;
        end
        default: begin
          state  <= PH_IDLE;
          ilim_q <= 1'b0;
        end
      endcase
    end
  end

  assign sw_en   = (state == PH_ON);
  assign ilim_en = ilim_q;

  a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_on |=> (!sw_en && !ilim_en));

  a_r8_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!sw_en && !ilim_en));

  a_r4_reverse_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && rev_s) |=> !sw_en);

  a_r3_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_SPENT) && ls_on) |=> !sw_en);

  a_r5_arm_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> ilim_en);

  a_r5_arm_needs_switch: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_en |-> sw_en);

  a_r6_stay_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !ilim_en) |=> !ilim_en);
endmodule

// File: rtl/bst_phase_seq.sv
module bst_phase_seq
  import bst_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ls_cmd,
  input  logic rev_flag,
  input  logic olim_flag,
  input  logic aux_good,
  output logic bst_gate_en,
  output logic ilim_arm
);
  logic [NUM_FLAGS-1:0] flags_raw;
  logic [NUM_FLAGS-1:0] flags_s;

  always_comb begin
    flags_raw            = '0;
    flags_raw[FLAG_REV]  = rev_flag;
    flags_raw[FLAG_OLIM] = olim_flag;
  end

  flag_sync #(
    .WIDTH (NUM_FLAGS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(flags_raw),
    .sync_out(flags_s)
  );

  phase_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ls_on   (ls_cmd),
    .pwr_good(aux_good),
    .rev_s   (flags_s[FLAG_REV]),
    .olim_s  (flags_s[FLAG_OLIM]),
    .sw_en   (bst_gate_en),
    .ilim_en (ilim_arm)
  );
endmodule

// File: tb/tb_bst_phase_seq.sv
module tb_bst_phase_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ls_cmd = 1'b0;
  logic rev_flag = 1'b0;
  logic olim_flag = 1'b0;
  logic aux_good = 1'b0;
  logic bst_gate_en;
  logic ilim_arm;

  int n_vec = 0;
  int n_bad = 0;

  // reference model: 0 idle, 1 on, 2 spent
  int    m_st = 0;
  bit    m_il = 1'b0;
  bit    m_r1 = 1'b0, m_r2 = 1'b0, m_o1 = 1'b0, m_o2 = 1'b0;
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bst_phase_seq dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ls_cmd     (ls_cmd),
    .rev_flag   (rev_flag),
    .olim_flag  (olim_flag),
    .aux_good   (aux_good),
    .bst_gate_en(bst_gate_en),
    .ilim_arm   (ilim_arm)
  );

  function automatic bit [1:0] expected();
    return {(m_st == 1), m_il};
  endfunction

  task automatic compare_now();
    @(negedge clk);
    n_vec++;
    if ({bst_gate_en, ilim_arm} !== expected()) begin
      n_bad++;
      $display("FAIL %s: {gate,ilim} actual %b%b expected %b", m_tag,
               bst_gate_en, ilim_arm, expected());
    end
  endtask

  task automatic apply(bit ls, bit rv, bit ol, bit pg, string ovr);
    bit    rev_s, ol_s;
    string t;
    ls_cmd = ls; rev_flag = rv; olim_flag = ol; aux_good = pg;
    rev_s = m_r2; ol_s = m_o2;
    if (!ls) begin
      m_st = 0; m_il = 1'b0; t = "R1";
    end else if (!pg) begin
      t = (m_st == 0) ? "R9" : "R8";
      m_st = 2; m_il = 1'b0;
    end else if (m_st == 0) begin
      m_st = 1; m_il = 1'b1; t = "R2";
    end else if (m_st == 1) begin
      if (rev_s) begin
        m_st = 2; m_il = 1'b0; t = "R4";
      end else if (!ol_s) begin
        m_il = 1'b0; t = "R6";
      end else begin
        t = m_il ? "R5" : "R6";
      end
    end else begin
      t = "R3";
    end
    m_r2 = m_r1; m_r1 = rv;
    m_o2 = m_o1; m_o1 = ol;
    m_tag = (ovr != "") ? ovr : t;
  endtask

  task automatic step(bit ls, bit rv, bit ol, bit pg, string ovr = "");
    apply(ls, rv, ol, pg, ovr);
    compare_now();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL all: watchdog expired, actual still running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    // reset state, R1
    repeat (3) @(negedge clk);
    n_vec++;
    if (bst_gate_en !== 1'b0 || ilim_arm !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset {gate,ilim} actual %b%b expected 00", bst_gate_en, ilim_arm);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);

    // over-limit held high through turn-on, then drops: R5, R7, R6
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R1");
    step(1, 0, 1, 1, "R2");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, "R5");
    step(1, 0, 0, 1, "R7");
    step(1, 0, 0, 1, "R7");
    step(1, 0, 0, 1, "R6");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, "R6");
    // single-cycle reverse pulse acts two edges later: R7, R4, R3
    step(1, 1, 1, 1, "R7");
    step(1, 0, 1, 1, "R7");
    step(1, 0, 1, 1, "R4");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, "R3");
    step(1, 1, 1, 1, "R3");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, "R3");
    step(0, 0, 1, 1, "R1");

    // over-limit already low at turn-on: R5 then R6
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R1");
    step(1, 0, 0, 1, "R5");
    step(1, 0, 0, 1, "R6");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, "R6");
    // power-good drop mid-phase: R8
    step(1, 0, 1, 0, "R8");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, "R8");
    step(0, 0, 1, 1, "R1");

    // phase start while power-good low: R9
    step(1, 0, 1, 0, "R9");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, "R9");
    step(0, 0, 1, 1, "R1");
    step(1, 0, 1, 1, "R2");
    step(0, 0, 1, 1, "R1");
    step(1, 0, 1, 1, "R2");

    // reverse flag raised just before turn-on: R7
    step(0, 1, 1, 1, "R1");
    step(1, 0, 1, 1, "R2");
    step(1, 0, 1, 1, "R7");
    step(0, 0, 1, 1, "R1");

    // constrained random phases
    for (int p = 0; p < 250; p++) begin
      int len;
      bit ol;
      len = 1 + int'($urandom_range(0, 14));
      ol  = $urandom_range(0, 1) == 1;
      for (int c = 0; c < len; c++) begin
        if ($urandom_range(0, 5) == 0) ol = ~ol;
        step(1, $urandom_range(0, 9) == 0, ol, $urandom_range(0, 24) != 0);
      end
      for (int c = 0; c < 1 + int'($urandom_range(0, 3)); c++)
        step(0, $urandom_range(0, 5) == 0, ol, $urandom_range(0, 9) != 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule